// File: doc/BRIEF.md
# Masked-Page ASID Translation Buffer

A small, fully associative translation buffer. Each slot holds one pair of pages: an even frame and an odd frame that share a virtual page-pair number, a page-size mask, an address-space identifier and a global flag. Each frame half has its own frame number and its own cacheable, dirty and valid bits. A lookup presents a virtual page number and an ASID, and gets back a hit flag, the winning slot, the selected frame half and that half's attributes. All of this happens in the same cycle.

A second, independent search port (the probe) returns the slot index, or an all-ones code when nothing matches. Software-style maintenance goes through three other paths. An indexed write replaces a whole slot. A round-robin read pointer exposes one slot as packed register images and can step to the next slot. A flush empties the table and resets the pointer. A separate flag marks the looked-up page as uncacheable when its address falls in the high uncached window.

Top module: `masked_asid_tlb`

## Requirements
- R1: A slot matches a query when the slot is live (either frame-half valid bit set) and its stored page-pair number equals the query's on every bit where the slot's mask holds a 0. Stored page-pair bits under mask ones are ignored.
- R2: A slot whose global flag is set matches any query ASID. Otherwise the query ASID must equal the stored ASID.
- R3: When several slots match, the lookup and the probe both report the lowest-numbered one.
- R4: The probe returns the matching slot index zero-extended to IW+1 bits. When no slot matches it returns all ones (15 for 8 slots).
- R5: The lookup page input carries the frame-half select bit at bit 0 and the page-pair number above it. The half is selected by the page bit at position t, where t is the count of trailing ones in the winning slot's mask. Hit is raised only if that half's valid bit is set, and the frame number, cacheable and dirty outputs come from that half.
- R6: The read port shows the slot at the pointer as packed images. The high image is the page-pair number shifted left by 11, ORed with the ASID. The mask image is the mask shifted left by 11. Each frame image is the frame number shifted left by 6, with cacheable at bit 3, dirty at bit 2, valid at bit 1 and the global flag at bit 0.
- R7: A write whose index is ENTRIES or more changes no slot, and it raises the error flag in the following cycle. An in-range write replaces every field of the slot, and in the following cycle the error flag is low.
- R8: Flush clears every slot (both valid bits included) and returns the read pointer to 0. Flush takes priority over a write in the same cycle.
- R9: The uncacheable flag is high exactly when the lookup address (page number shifted left by 12), ANDed with 0xA0000000, equals 0xA0000000.
- R10: With the step input high, the read pointer advances by one at the clock edge, and it wraps from ENTRIES-1 to 0. With the step input low it holds.
- R11: Lookup, probe and the uncacheable flag are combinational in the current table contents. A write becomes visible only after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; empties the table |
| flush | input | 1 | Clear all slots and the read pointer |
| lk_page | input | VA_W-PG_SHIFT | Lookup page number (bit 0 is the half-select base) |
| lk_asid | input | ASID_W | Lookup address-space ID |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IW | Winning slot |
| lk_odd | output | 1 | Selected frame half (1 = odd) |
| lk_pfn | output | PFN_W | Frame number of the selected half |
| lk_cache | output | 1 | Cacheable bit of the selected half |
| lk_dirty | output | 1 | Dirty bit of the selected half |
| lk_uncached | output | 1 | Page lies in the uncached window |
| pr_vpn | input | VPN_W | Probe page-pair number |
| pr_asid | input | ASID_W | Probe ASID |
| pr_idx | output | IW+1 | Probe result, all ones if not found |
| wr_en | input | 1 | Indexed write strobe |
| wr_idx | input | IW+1 | Write slot index |
| wr_vpn | input | VPN_W | Page-pair number to store |
| wr_mask | input | VPN_W | Page-size mask (contiguous low ones) |
| wr_asid | input | ASID_W | ASID to store |
| wr_global | input | 1 | Global flag |
| wr_pfn0 | input | PFN_W | Even-half frame number |
| wr_pfn1 | input | PFN_W | Odd-half frame number |
| wr_cdv0 | input | 3 | Even-half {cacheable, dirty, valid} |
| wr_cdv1 | input | 3 | Odd-half {cacheable, dirty, valid} |
| wr_err | output | 1 | Previous-cycle write was out of range |
| rd_next | input | 1 | Step the read pointer |
| rd_idx | output | IW | Read pointer |
| rd_hi | output | VPN_W+11 | High image of the slot at the pointer |
| rd_mask | output | VPN_W+11 | Mask image |
| rd_lo0 | output | PFN_W+6 | Even-half image |
| rd_lo1 | output | PFN_W+6 | Odd-half image |

## Verification
Lookup, probe, uncacheable and read-image results are due in the same cycle as their inputs or the pointer value. The bench drives these inputs on the falling edge and samples them 2 ns later, before the next rising edge. Writes, flushes and pointer steps take effect at the next rising edge, and wr_err appears one cycle after the write. The bench holds such a stimulus for one cycle and checks on the following falling edge. For R11 it also checks, before that edge, that the table still answers with its old contents.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // register image layout
  localparam int HI_SHIFT  = 11;
  localparam int LO_SHIFT  = 6;
  localparam int LO_C_BIT  = 3;
  localparam int LO_D_BIT  = 2;
  localparam int LO_V_BIT  = 1;
  localparam int LO_G_BIT  = 0;
  // attribute triple ordering on the write port
  localparam int CDV_C = 2;
  localparam int CDV_D = 1;
  localparam int CDV_V = 0;
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int N      = 8,
  parameter int VPN_W  = 19,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 20,
  parameter int IW     = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            flush,
  input  logic                            wr_en,
  input  logic [IW:0]                     wr_idx,
  input  logic [VPN_W-1:0]                wr_vpn,
  input  logic [VPN_W-1:0]                wr_mask,
  input  logic [ASID_W-1:0]               wr_asid,
  input  logic                            wr_g,
  input  logic [1:0][PFN_W-1:0]           wr_pfn,
  input  logic [1:0]                      wr_c,
  input  logic [1:0]                      wr_d,
  input  logic [1:0]                      wr_v,
  output logic [N-1:0][VPN_W-1:0]         e_vpn,
  output logic [N-1:0][VPN_W-1:0]         e_mask,
  output logic [N-1:0][ASID_W-1:0]        e_asid,
  output logic [N-1:0]                    e_g,
  output logic [N-1:0][1:0][PFN_W-1:0]    e_pfn,
  output logic [N-1:0][1:0]               e_c,
  output logic [N-1:0][1:0]               e_d,
  output logic [N-1:0][1:0]               e_v,
  output logic                            wr_err
);
  localparam logic [IW:0] LIMIT = (IW+1)'(N);

  logic wr_bad;
  assign wr_bad = wr_en && (wr_idx >= LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_err <= 1'b0;
    else        wr_err <= wr_bad;
  end

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic take;
    assign take = wr_en && (wr_idx == (IW+1)'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        e_vpn[g]  <= '0;
        e_mask[g] <= '0;
        e_asid[g] <= '0;
        e_g[g]    <= 1'b0;
        e_pfn[g]  <= '0;
        e_c[g]    <= '0;
        e_d[g]    <= '0;
        e_v[g]    <= '0;
      end else if (flush) begin
        e_vpn[g]  <= '0;
        e_mask[g] <= '0;
        e_asid[g] <= '0;
        e_g[g]    <= 1'b0;
        e_pfn[g]  <= '0;
        e_c[g]    <= '0;
        e_d[g]    <= '0;
        e_v[g]    <= '0;
      end else if (take) begin
        e_vpn[g]  <= wr_vpn;
        e_mask[g] <= wr_mask;
        e_asid[g] <= wr_asid;
        e_g[g]    <= wr_g;
        e_pfn[g]  <= wr_pfn;
        e_c[g]    <= wr_c;
        e_d[g]    <= wr_d;
        e_v[g]    <= wr_v;
      end
    end
  end
endmodule

// File: rtl/tlb_match_array.sv
module tlb_match_array #(
  parameter int N      = 8,
  parameter int VPN_W  = 19,
  parameter int ASID_W = 8,
  parameter int IW     = 3
) (
  input  logic [N-1:0][VPN_W-1:0]  e_vpn,
  input  logic [N-1:0][VPN_W-1:0]  e_mask,
  input  logic [N-1:0][ASID_W-1:0] e_asid,
  input  logic [N-1:0]             e_g,
  input  logic [N-1:0]             e_live,
  input  logic [VPN_W-1:0]         q_vpn,
  input  logic [ASID_W-1:0]        q_asid,
  output logic [N-1:0]             first_vec,
  output logic                     found,
  output logic [IW-1:0]            idx
);
  function automatic logic slot_hit(
    input logic [VPN_W-1:0]  svpn,
    input logic [VPN_W-1:0]  smask,
    input logic [ASID_W-1:0] sasid,
    input logic              sg,
    input logic              slive,
    input logic [VPN_W-1:0]  qv,
    input logic [ASID_W-1:0] qa
  );
    logic page_eq, id_eq;
    page_eq = ((svpn ^ qv) & ~smask) == '0;
    id_eq   = sg || (sasid == qa);
    return slive && page_eq && id_eq;
  endfunction

  logic [N-1:0] raw;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign raw[g] = slot_hit(e_vpn[g], e_mask[g], e_asid[g], e_g[g], e_live[g],
                             q_vpn, q_asid);
  end

  // isolate the lowest set bit: lowest index wins
  assign first_vec = raw & (~raw + 1'b1);
  assign found     = |raw;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (raw[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/tlb_victim_ptr.sv
module tlb_victim_ptr #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          step,
  output logic [IW-1:0] ptr
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr <= '0;
    else if (flush) ptr <= '0;
    else if (step)  ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/masked_asid_tlb.sv
module masked_asid_tlb #(
  parameter int             ENTRIES  = 8,
  parameter int             VA_W     = 32,
  parameter int             PG_SHIFT = 12,
  parameter int             ASID_W   = 8,
  parameter int             PFN_W    = 20,
  parameter logic [31:0]    UC_PAT   = 32'hA000_0000,
  localparam int            IW       = $clog2(ENTRIES),
  localparam int            PN_W     = VA_W - PG_SHIFT,
  localparam int            VPN_W    = PN_W - 1,
  localparam int            HI_W     = VPN_W + tlb_pkg::HI_SHIFT,
  localparam int            LO_W     = PFN_W + tlb_pkg::LO_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [PN_W-1:0]   lk_page,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic [IW-1:0]     lk_idx,
  output logic              lk_odd,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic              lk_cache,
  output logic              lk_dirty,
  output logic              lk_uncached,
  input  logic [VPN_W-1:0]  pr_vpn,
  input  logic [ASID_W-1:0] pr_asid,
  output logic [IW:0]       pr_idx,
  input  logic              wr_en,
  input  logic [IW:0]       wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [VPN_W-1:0]  wr_mask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [PFN_W-1:0]  wr_pfn0,
  input  logic [PFN_W-1:0]  wr_pfn1,
  input  logic [2:0]        wr_cdv0,
  input  logic [2:0]        wr_cdv1,
  output logic              wr_err,
  input  logic              rd_next,
  output logic [IW-1:0]     rd_idx,
  output logic [HI_W-1:0]   rd_hi,
  output logic [HI_W-1:0]   rd_mask,
  output logic [LO_W-1:0]   rd_lo0,
  output logic [LO_W-1:0]   rd_lo1
);
  import tlb_pkg::*;

  localparam logic [PN_W-1:0] UC_PG = UC_PAT[VA_W-1:PG_SHIFT];

  // ---------------- arithmetic helpers ----------------
  function automatic logic pick_odd(input logic [PN_W-1:0] page,
                                    input logic [VPN_W-1:0] msk);
    logic [PN_W-1:0] ext, onehot;
    ext    = {1'b0, msk};
    onehot = ~ext & (ext + 1'b1);   // lowest zero of the mask
    return |(page & onehot);
  endfunction

  function automatic logic [HI_W-1:0] pack_hi(input logic [VPN_W-1:0] v,
                                              input logic [ASID_W-1:0] a);
    logic [HI_W-1:0] img;
    img = '0;
    img[HI_W-1:HI_SHIFT] = v;
    img[ASID_W-1:0]      = a;
    return img;
  endfunction

  function automatic logic [LO_W-1:0] pack_lo(input logic [PFN_W-1:0] f,
                                              input logic c, input logic d,
                                              input logic v, input logic g);
    logic [LO_W-1:0] img;
    img = '0;
    img[LO_W-1:LO_SHIFT] = f;
    img[LO_C_BIT]        = c;
    img[LO_D_BIT]        = d;
    img[LO_V_BIT]        = v;
    img[LO_G_BIT]        = g;
    return img;
  endfunction

  // ---------------- storage ----------------
  logic [ENTRIES-1:0][VPN_W-1:0]      e_vpn, e_mask;
  logic [ENTRIES-1:0][ASID_W-1:0]     e_asid;
  logic [ENTRIES-1:0]                 e_g, e_live;
  logic [ENTRIES-1:0][1:0][PFN_W-1:0] e_pfn;
  logic [ENTRIES-1:0][1:0]            e_c, e_d, e_v;

  logic [1:0][PFN_W-1:0] w_pfn;
  logic [1:0]            w_c, w_d, w_v;
  assign w_pfn = {wr_pfn1, wr_pfn0};
  assign w_c   = {wr_cdv1[CDV_C], wr_cdv0[CDV_C]};
  assign w_d   = {wr_cdv1[CDV_D], wr_cdv0[CDV_D]};
  assign w_v   = {wr_cdv1[CDV_V], wr_cdv0[CDV_V]};

  tlb_entry_store #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W), .IW(IW)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_mask(wr_mask),
    .wr_asid(wr_asid), .wr_g(wr_global), .wr_pfn(w_pfn), .wr_c(w_c), .wr_d(w_d), .wr_v(w_v),
    .e_vpn(e_vpn), .e_mask(e_mask), .e_asid(e_asid), .e_g(e_g),
    .e_pfn(e_pfn), .e_c(e_c), .e_d(e_d), .e_v(e_v), .wr_err(wr_err)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_live
    assign e_live[g] = |e_v[g];
  end

  // ---------------- lookup ----------------
  logic [ENTRIES-1:0] lk_first;
  logic               lk_found;
  logic [IW-1:0]      lk_i;

  tlb_match_array #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .IW(IW)) u_lk (
    .e_vpn(e_vpn), .e_mask(e_mask), .e_asid(e_asid), .e_g(e_g), .e_live(e_live),
    .q_vpn(lk_page[PN_W-1:1]), .q_asid(lk_asid),
    .first_vec(lk_first), .found(lk_found), .idx(lk_i)
  );

  assign lk_idx   = lk_i;
  assign lk_odd   = pick_odd(lk_page, e_mask[lk_i]);
  assign lk_hit   = lk_found && e_v[lk_i][lk_odd];
  assign lk_pfn   = e_pfn[lk_i][lk_odd];
  assign lk_cache = e_c[lk_i][lk_odd];
  assign lk_dirty = e_d[lk_i][lk_odd];

  assign lk_uncached = (lk_page & UC_PG) == UC_PG;

  // ---------------- probe ----------------
  logic [ENTRIES-1:0] pr_first;
  logic               pr_found;
  logic [IW-1:0]      pr_i;

  tlb_match_array #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .IW(IW)) u_pr (
    .e_vpn(e_vpn), .e_mask(e_mask), .e_asid(e_asid), .e_g(e_g), .e_live(e_live),
    .q_vpn(pr_vpn), .q_asid(pr_asid),
    .first_vec(pr_first), .found(pr_found), .idx(pr_i)
  );

  assign pr_idx = pr_found ? {1'b0, pr_i} : '1;

  // ---------------- indexed read ----------------
  tlb_victim_ptr #(.N(ENTRIES), .IW(IW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .flush(flush), .step(rd_next), .ptr(rd_idx)
  );

  always_comb begin
    rd_hi   = pack_hi(e_vpn[rd_idx], e_asid[rd_idx]);
    rd_mask = '0;
    rd_mask[HI_W-1:HI_SHIFT] = e_mask[rd_idx];
    rd_lo0  = pack_lo(e_pfn[rd_idx][0], e_c[rd_idx][0], e_d[rd_idx][0],
                      e_v[rd_idx][0], e_g[rd_idx]);
    rd_lo1  = pack_lo(e_pfn[rd_idx][1], e_c[rd_idx][1], e_d[rd_idx][1],
                      e_v[rd_idx][1], e_g[rd_idx]);
  end
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          rd_next,
  input logic [IW-1:0] rd_idx,
  input logic          wr_en,
  input logic [IW:0]   wr_idx,
  input logic          wr_err,
  input logic          lk_hit,
  input logic [IW:0]   pr_idx,
  input logic [N-1:0]  lk_first,
  input logic [N-1:0]  pr_first
);
  localparam logic [IW:0]   LIMIT = (IW+1)'(N);
  localparam logic [IW-1:0] LAST  = IW'(N - 1);

  logic bad_wr;
  assign bad_wr = wr_en && (wr_idx >= LIMIT);

  // R7: an out-of-range write flags an error next cycle
  p_bad_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> wr_err);

  // R7: any other cycle leaves the flag low next cycle
  p_good_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_wr |=> !wr_err);

  // R8: after a flush nothing hits and the probe finds nothing
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!lk_hit && (pr_idx == '1) && (rd_idx == '0)));

  // R10: pointer wraps from the last slot
  p_ptr_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_next && !flush && rd_idx == LAST) |=> (rd_idx == '0));

  // R10: pointer steps by one below the last slot
  p_ptr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_next && !flush && rd_idx != LAST) |=> (rd_idx == $past(rd_idx) + 1'b1));

  // R10: pointer holds without a step
  p_ptr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_next && !flush) |=> $stable(rd_idx));

  // R3: at most one winner per search port
  p_single_winner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_first) && $onehot0(pr_first));

  // R5: a hit always has a winning slot
  p_hit_has_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_first != '0));
endmodule

bind masked_asid_tlb tlb_checker #(.N(ENTRIES), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .rd_next(rd_next), .rd_idx(rd_idx),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_err(wr_err), .lk_hit(lk_hit),
  .pr_idx(pr_idx), .lk_first(lk_first), .pr_first(pr_first)
);

// File: tb/sim_masked_asid_tlb.sv
module sim_masked_asid_tlb;
  localparam int TCLK = 10;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic [19:0] lk_page = '0;
  logic [7:0]  lk_asid = '0;
  logic lk_hit, lk_odd, lk_cache, lk_dirty, lk_uncached;
  logic [2:0]  lk_idx;
  logic [19:0] lk_pfn;
  logic [18:0] pr_vpn = '0;
  logic [7:0]  pr_asid = '0;
  logic [3:0]  pr_idx;
  logic wr_en = 1'b0, wr_global = 1'b0, wr_err;
  logic [3:0]  wr_idx = '0;
  logic [18:0] wr_vpn = '0, wr_mask = '0;
  logic [7:0]  wr_asid = '0;
  logic [19:0] wr_pfn0 = '0, wr_pfn1 = '0;
  logic [2:0]  wr_cdv0 = '0, wr_cdv1 = '0;
  logic rd_next = 1'b0;
  logic [2:0]  rd_idx;
  logic [29:0] rd_hi, rd_mask;
  logic [25:0] rd_lo0, rd_lo1;

  always #(TCLK/2) clk = ~clk;

  masked_asid_tlb u0 (.*);

  int errors = 0, checks = 0;
  bit finished = 1'b0;

  // bench model of the table
  logic [18:0] m_vpn [N], m_mask [N];
  logic [7:0]  m_asid [N];
  logic        m_g [N];
  logic [19:0] m_pfn [N][2];
  logic        m_c [N][2], m_d [N][2], m_v [N][2];
  int          m_ptr = 0;

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int trailing_ones(input logic [18:0] m);
    int t = 0;
    while (t < 19 && m[t]) t++;
    return t;
  endfunction

  // expected winner: -1 if none
  function automatic int model_find(input logic [18:0] v, input logic [7:0] a);
    for (int i = 0; i < N; i++) begin
      bit live = m_v[i][0] | m_v[i][1];
      bit ok = 1'b1;
      for (int b = 0; b < 19; b++)
        if (!m_mask[i][b] && (v[b] != m_vpn[i][b])) ok = 1'b0;
      if (live && ok && (m_g[i] || m_asid[i] == a)) return i;
    end
    return -1;
  endfunction

  task automatic do_write(input int idx, input logic [18:0] v, input logic [18:0] msk,
                          input logic [7:0] a, input logic g,
                          input logic [19:0] f0, input logic [19:0] f1,
                          input logic [2:0] k0, input logic [2:0] k1);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_vpn = v; wr_mask = msk; wr_asid = a;
    wr_global = g; wr_pfn0 = f0; wr_pfn1 = f1; wr_cdv0 = k0; wr_cdv1 = k1;
    @(negedge clk);
    wr_en = 1'b0;
    check("R7", "error flag after write", longint'(wr_err), longint'(idx >= N));
    if (idx < N) begin
      m_vpn[idx] = v; m_mask[idx] = msk; m_asid[idx] = a; m_g[idx] = g;
      m_pfn[idx][0] = f0; m_pfn[idx][1] = f1;
      m_c[idx][0] = k0[2]; m_d[idx][0] = k0[1]; m_v[idx][0] = k0[0];
      m_c[idx][1] = k1[2]; m_d[idx][1] = k1[1]; m_v[idx][1] = k1[0];
    end
  endtask

  // lookup + probe check, inputs driven after a falling edge
  task automatic lookup_check(input logic [19:0] page, input logic [7:0] a, input string req);
    int w, t;
    bit odd, exp_hit;
    @(negedge clk);
    lk_page = page; lk_asid = a; pr_vpn = page[19:1]; pr_asid = a;
    #2;
    w = model_find(page[19:1], a);
    check("R4", "probe index", longint'(pr_idx), (w < 0) ? 64'd15 : longint'(w));
    if (w < 0) begin
      check(req, "miss", longint'(lk_hit), 0);
    end else begin
      t = trailing_ones(m_mask[w]);
      odd = page[t];
      exp_hit = m_v[w][odd];
      check(req, "hit", longint'(lk_hit), longint'(exp_hit));
      check(req, "index", longint'(lk_idx), longint'(w));
      check("R5", "half select", longint'(lk_odd), longint'(odd));
      if (exp_hit) begin
        check("R5", "frame", longint'(lk_pfn), longint'(m_pfn[w][odd]));
        check("R5", "attrs", longint'({lk_cache, lk_dirty}),
              longint'({m_c[w][odd], m_d[w][odd]}));
      end
    end
  endtask

  task automatic readback_one();
    longint hi, lo0, lo1;
    int p = m_ptr;
    #2;
    hi  = (longint'(m_vpn[p]) << 11) + longint'(m_asid[p]);
    lo0 = (longint'(m_pfn[p][0]) << 6) + 8*m_c[p][0] + 4*m_d[p][0] + 2*m_v[p][0] + m_g[p];
    lo1 = (longint'(m_pfn[p][1]) << 6) + 8*m_c[p][1] + 4*m_d[p][1] + 2*m_v[p][1] + m_g[p];
    check("R10", "read pointer", longint'(rd_idx), longint'(p));
    check("R6", "high image", longint'(rd_hi), hi);
    check("R6", "mask image", longint'(rd_mask), longint'(m_mask[p]) << 11);
    check("R6", "even image", longint'(rd_lo0), lo0);
    check("R6", "odd image", longint'(rd_lo1), lo1);
  endtask

  task automatic sweep_read(input int count);
    for (int i = 0; i < count; i++) begin
      @(negedge clk);
      readback_one();
      rd_next = 1'b1;
      @(negedge clk);
      rd_next = 1'b0;
      m_ptr = (m_ptr + 1) % N;
    end
  endtask

  task automatic load_table();
    do_write(0, 19'h00100, 19'h0,  8'd0, 1'b0, 20'h00A00, 20'h00A01, 3'b101, 3'b011);
    do_write(1, 19'h00200, 19'h1,  8'd1, 1'b0, 20'h01100, 20'h01101, 3'b111, 3'b010);
    do_write(2, 19'h00300, 19'h3,  8'd2, 1'b0, 20'h02200, 20'h02201, 3'b000, 3'b101);
    do_write(3, 19'h01000, 19'hF,  8'd3, 1'b0, 20'h03300, 20'h03301, 3'b011, 3'b111);
    do_write(4, 19'h02000, 19'h0,  8'd0, 1'b0, 20'h04400, 20'h04401, 3'b110, 3'b110);
    do_write(5, 19'h04000, 19'h0,  8'd1, 1'b1, 20'h05500, 20'h05501, 3'b001, 3'b101);
    do_write(6, 19'h00300, 19'h3,  8'd1, 1'b0, 20'h06600, 20'h06601, 3'b111, 3'b001);
    do_write(7, 19'h01005, 19'h0,  8'd3, 1'b0, 20'h07700, 20'h07701, 3'b101, 3'b011);
  endtask

  initial begin
    #(TCLK * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_vpn[i] = '0; m_mask[i] = '0; m_asid[i] = '0; m_g[i] = 0;
      for (int h = 0; h < 2; h++) begin
        m_pfn[i][h] = '0; m_c[i][h] = 0; m_d[i][h] = 0; m_v[i][h] = 0;
      end
    end
    #(TCLK * 3);
    @(negedge clk);
    // reset state (R8 empty table view)
    check("R8", "reset pointer", longint'(rd_idx), 0);
    check("R4", "reset probe", longint'(pr_idx), 15);
    check("R8", "reset hit", longint'(lk_hit), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7", "reset error flag", longint'(wr_err), 0);

    load_table();

    // R6 and R10: read images over nine steps (wraps)
    sweep_read(N + 1);
    @(negedge clk);
    #2;
    check("R10", "hold without step", longint'(rd_idx), longint'(m_ptr));

    // R2: global slot answers any ASID
    for (int a = 0; a < 4; a++) lookup_check({19'h04000, 1'b1}, 8'(a), "R2");
    // R1: masked bits ignored, unmasked bits compared
    lookup_check({19'h01009, 1'b0}, 8'd3, "R1");
    lookup_check({19'h01019, 1'b0}, 8'd3, "R1");
    lookup_check({19'h00100, 1'b0}, 8'd1, "R1");
    // R3: slot 3 and slot 7 both cover 0x01005 for ASID 3
    lookup_check({19'h01005, 1'b0}, 8'd3, "R3");
    // R5: slot 1 odd half invalid, slot 4 not live
    lookup_check({19'h00201, 1'b0}, 8'd1, "R5");
    lookup_check({19'h00200, 1'b1}, 8'd1, "R5");
    lookup_check({19'h02000, 1'b0}, 8'd0, "R5");

    // targeted random sweep around stored slots
    for (int n = 0; n < 3000; n++) begin
      int k = $urandom % N;
      logic [18:0] v = m_vpn[k] ^ (19'($urandom) & (m_mask[k] | 19'h1));
      lookup_check({v, 1'($urandom)}, 8'($urandom % 4), "R1");
    end

    // R11: a write is invisible until its edge
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd4; wr_vpn = 19'h02000; wr_mask = '0; wr_asid = 8'd0;
    wr_global = 1'b0; wr_pfn0 = 20'h0ABCD; wr_pfn1 = 20'h0DCBA; wr_cdv0 = 3'b111; wr_cdv1 = 3'b001;
    lk_page = {19'h02000, 1'b0}; lk_asid = 8'd0;
    #2;
    check("R11", "old contents before edge", longint'(lk_hit), 0);
    @(negedge clk);
    wr_en = 1'b0;
    #2;
    check("R11", "new contents after edge", longint'(lk_hit), 1);
    check("R11", "new frame after edge", longint'(lk_pfn), 20'h0ABCD);
    m_vpn[4] = 19'h02000; m_mask[4] = '0; m_asid[4] = 0; m_g[4] = 0;
    m_pfn[4][0] = 20'h0ABCD; m_pfn[4][1] = 20'h0DCBA;
    m_c[4][0] = 1; m_d[4][0] = 1; m_v[4][0] = 1; m_c[4][1] = 0; m_d[4][1] = 0; m_v[4][1] = 1;

    // R3: retarget slot 3 to ASID 0, slot 7 becomes the winner
    do_write(3, 19'h01000, 19'hF, 8'd0, 1'b0, 20'h03300, 20'h03301, 3'b011, 3'b111);
    lookup_check({19'h01005, 1'b1}, 8'd3, "R3");

    // R7: out-of-range writes change nothing
    for (int i = N; i < 16; i++)
      do_write(i, 19'h7FFFF, 19'h0, 8'd9, 1'b1, 20'hFFFFF, 20'hFFFFF, 3'b111, 3'b111);
    lookup_check({19'h7FFFF, 1'b0}, 8'd9, "R7");
    sweep_read(N);

    // R9: uncacheable window sweep
    for (int t = 0; t < 16; t++) begin
      for (int r = 0; r < 4; r++) begin
        logic [19:0] pg = {4'(t), 16'($urandom)};
        logic [31:0] va = {pg, 12'h0};
        @(negedge clk);
        lk_page = pg;
        #2;
        check("R9", "uncached flag", longint'(lk_uncached),
              longint'((va & 32'hA000_0000) == 32'hA000_0000));
      end
    end

    // R8: flush beats a simultaneous write, clears all, pointer to 0
    @(negedge clk);
    rd_next = 1'b1;
    @(negedge clk);
    rd_next = 1'b0;
    flush = 1'b1; wr_en = 1'b1; wr_idx = 4'd2; wr_cdv0 = 3'b001;
    @(negedge clk);
    flush = 1'b0; wr_en = 1'b0;
    #2;
    check("R8", "pointer after flush", longint'(rd_idx), 0);
    for (int i = 0; i < N; i++) begin
      m_vpn[i] = '0; m_mask[i] = '0; m_asid[i] = '0; m_g[i] = 0;
      for (int h = 0; h < 2; h++) begin
        m_pfn[i][h] = '0; m_c[i][h] = 0; m_d[i][h] = 0; m_v[i][h] = 0;
      end
    end
    m_ptr = 0;
    lookup_check({19'h00300, 1'b0}, 8'd2, "R8");
    lookup_check(20'h0, 8'd0, "R8");
    sweep_read(N);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule